// File: doc/BRIEF.md
# Nested Enable/Set Strobe Generator with Byte Transfer Bank

The block divides a fast reference clock by four and produces four slow timing signals: a base clock, a copy of it lagging by a quarter period, an enable strobe formed as the OR of the two, and a set strobe formed as their AND. The set pulse sits strictly inside the enable window. The enable window therefore brackets every capture, and a destination register can only latch while the source is still driving.

The strobes run a register-to-register move over one shared byte bus. A small bank of byte registers hangs on that bus. Selecting a source index at or above the bank size drives the bus from an external byte input instead, which is how values enter the bank. A move request is taken only at the start of a base period. It then occupies exactly that one period: the source drives during enable and the destination captures during set.

Top module: `xfer_strobe_core`

## Requirements
- R1: While reset is asserted, and until the release has passed the two-stage synchronizer, all four strobes are low, the bus reads zero and every bank register is cleared. An asynchronous reset at any time returns the block to this state.
- R2: The base clock rises on the third reference edge after reset release. It is then high for two reference cycles and low for two, with phase 0 being the first high cycle.
- R3: The delayed clock equals the base clock one reference cycle (a quarter base period) later, so it is high in phases 1 and 2.
- R4: The enable strobe equals the OR of base and delayed clock: it is high in phases 0, 1 and 2 and low in phase 3.
- R5: The set strobe equals the AND of base and delayed clock. It is high in phase 1 only, rising after enable rises and falling before enable falls.
- R6: The bus carries the selected source only while a move is active and enable is high. At all other times it reads zero.
- R7: The destination captures the bus at the end of phase 1. No bank register changes at any other time.
- R8: A request is sampled only at the edge that starts phase 0. A request present at any other edge is ignored, and an accepted move lasts exactly one base period.
- R9: When source and destination index are equal, the register keeps its value and no other register changes.
- R10: A source index of NREG or above selects the external byte input as the bus source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock, four times the base rate |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| xfer_req_i | input | 1 | Move request, sampled at the start of a base period |
| src_sel_i | input | SRC_W (3) | Source index; NREG or above selects ext_byte_i |
| dst_sel_i | input | DST_W (2) | Destination register index |
| ext_byte_i | input | DW (8) | External byte driven onto the bus when selected |
| clk_base_o | output | 1 | Base clock |
| clk_dly_o | output | 1 | Base clock delayed by a quarter period |
| en_strb_o | output | 1 | Enable strobe (OR) |
| set_strb_o | output | 1 | Set strobe (AND) |
| bus_o | output | DW (8) | Shared byte bus |

## Verification
All strobes are registered, so after the synchronizer they follow a bench-kept edge count: the outputs seen after reference edge n show phase (n-3) mod 4. A request driven during phase 3 is taken at the next edge. The bus shows the source in the three sampling slots that follow and reads zero in the fourth. A captured value becomes visible only through a later move that reads it back. The bench drives and samples on falling edges and derives every expected value from that phase count and its own copy of the register contents.

// File: rtl/xfer_strobe_pkg.sv
package xfer_strobe_pkg;

  typedef enum logic [1:0] {
    PH_RISE = 2'd0,
    PH_SET  = 2'd1,
    PH_FALL = 2'd2,
    PH_IDLE = 2'd3
  } phase_e;

  typedef struct packed {
    logic base;
    logic dly;
    logic en;
    logic set;
  } strobes_t;

  function automatic strobes_t decode_phase(phase_e ph);
    strobes_t s;
    s.base = (ph == PH_RISE) || (ph == PH_SET);
    s.dly  = (ph == PH_SET)  || (ph == PH_FALL);
    s.en   = (ph != PH_IDLE);
    s.set  = (ph == PH_SET);
    return s;
  endfunction

endpackage

// File: rtl/xfer_rst_sync.sv
module xfer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/xfer_phase_gen.sv
module xfer_phase_gen
  import xfer_strobe_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  output strobes_t strb_o,
  output logic     period_start_o
);
  phase_e   phase_q, phase_d;
  logic     run_q;
  strobes_t strb_q, strb_d;

  always_comb begin
    phase_d        = run_q ? phase_e'(phase_q + 2'd1) : PH_RISE;
    strb_d         = decode_phase(phase_d);
    period_start_o = !run_q || (phase_q == PH_IDLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_RISE;
      run_q   <= 1'b0;
      strb_q  <= '0;
    end else begin
      phase_q <= phase_d;
      run_q   <= 1'b1;
      strb_q  <= strb_d;
    end
  end

  assign strb_o = strb_q;

  // R2: base clock stays high / low for two reference cycles
  p_base_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strb_q.base) |=> strb_q.base);
  p_base_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb_q.base) |=> !strb_q.base);
  // R3: delayed clock is the base clock one reference cycle later
  p_dly_lag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_q.dly == $past(strb_q.base));
  // R4: enable covers both clocks
  p_en_or_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_q.en == (strb_q.base || strb_q.dly));
  // R5: set nested inside enable, one cycle wide
  p_set_in_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_q.set |-> strb_q.en);
  p_set_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strb_q.set) |-> $past(strb_q.en));
  p_en_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb_q.en) |-> $past(!strb_q.set));
  p_set_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_q.set |=> !strb_q.set);
endmodule

// File: rtl/xfer_reg_bank.sv
module xfer_reg_bank #(
  parameter int NREG  = 4,
  parameter int DW    = 8,
  parameter int SRC_W = $clog2(NREG + 1),
  parameter int DST_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  input  logic             set_i,
  input  logic             req_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [DST_W-1:0] dst_i,
  input  logic [DW-1:0]    ext_i,
  output logic [DW-1:0]    bus_o
);
  logic                      active_q, active_d;
  logic [SRC_W-1:0]          src_q, src_d;
  logic [DST_W-1:0]          dst_q, dst_d;
  logic [NREG-1:0][DW-1:0]   regs_q, regs_d;
  logic [DW-1:0]             src_byte;
  logic                      wr_en;

  // request sampling: only at period start
  always_comb begin
    active_d = active_q;
    src_d    = src_q;
    dst_d    = dst_q;
    if (start_i) begin
      active_d = req_i;
      src_d    = src_i;
      dst_d    = dst_i;
    end
  end

  // source mux: indices at or above NREG pick the external byte
  always_comb begin
    src_byte = ext_i;
    for (int i = 0; i < NREG; i++) begin
      if (src_q == SRC_W'(i)) src_byte = regs_q[i];
    end
  end

  assign bus_o = (active_q && en_i) ? src_byte : '0;
  assign wr_en = active_q && set_i;

  always_comb begin
    regs_d = regs_q;
    if (wr_en) begin
      for (int i = 0; i < NREG; i++) begin
        if (dst_q == DST_W'(i)) regs_d[i] = bus_o;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      src_q    <= '0;
      dst_q    <= '0;
    end else if (start_i) begin
      active_q <= active_d;
      src_q    <= src_d;
      dst_q    <= dst_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    regs_q <= '0;
    else if (wr_en) regs_q <= regs_d;
  end

  // R6: bus idle outside the enable window
  p_bus_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (bus_o == '0));
  // R7: bank changes only on the set phase of an active move
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(active_q && set_i) |=> $stable(regs_q));
  // R8: move state changes only at a period start
  p_period_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q != $past(active_q)) |-> $past(start_i));
  // R9: self move leaves the bank untouched
  p_self_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && set_i && (src_q == SRC_W'(dst_q))) |=> $stable(regs_q));
endmodule

// File: rtl/xfer_strobe_core.sv
module xfer_strobe_core
  import xfer_strobe_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int DW    = 8,
  parameter int SRC_W = $clog2(NREG + 1),
  parameter int DST_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xfer_req_i,
  input  logic [SRC_W-1:0] src_sel_i,
  input  logic [DST_W-1:0] dst_sel_i,
  input  logic [DW-1:0]    ext_byte_i,
  output logic             clk_base_o,
  output logic             clk_dly_o,
  output logic             en_strb_o,
  output logic             set_strb_o,
  output logic [DW-1:0]    bus_o
);
  logic     rst_int_n;
  strobes_t strb;
  logic     period_start;

  xfer_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  xfer_phase_gen u_phase (
    .clk_i          (clk_i),
    .rst_ni         (rst_int_n),
    .strb_o         (strb),
    .period_start_o (period_start)
  );

  xfer_reg_bank #(.NREG(NREG), .DW(DW), .SRC_W(SRC_W), .DST_W(DST_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .start_i (period_start),
    .en_i    (strb.en),
    .set_i   (strb.set),
    .req_i   (xfer_req_i),
    .src_i   (src_sel_i),
    .dst_i   (dst_sel_i),
    .ext_i   (ext_byte_i),
    .bus_o   (bus_o)
  );

  assign clk_base_o = strb.base;
  assign clk_dly_o  = strb.dly;
  assign en_strb_o  = strb.en;
  assign set_strb_o = strb.set;
endmodule

// File: tb/sim_xfer_strobe_core.sv
`timescale 1ns/1ps
module sim_xfer_strobe_core;
  localparam int NREG = 4;
  localparam int DW   = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req;
  logic [2:0] src;
  logic [1:0] dst;
  logic [7:0] ext;
  logic       base, dly, en, set;
  logic [7:0] bus;

  int checks = 0;
  int errors = 0;
  int ec = 0;
  logic [7:0] model [NREG];

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ec <= 0;
    else        ec <= ec + 1;
  end

  xfer_strobe_core #(.NREG(NREG), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .xfer_req_i(req), .src_sel_i(src),
    .dst_sel_i(dst), .ext_byte_i(ext), .clk_base_o(base), .clk_dly_o(dly),
    .en_strb_o(en), .set_strb_o(set), .bus_o(bus)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_phase(int p);
    @(negedge clk);
    while (!(ec >= 3 && ((ec - 3) % 4) == p)) @(negedge clk);
  endtask

  // R1 R2: reset state and first period
  task automatic t_reset;
    rst_n = 1'b0; req = 1'b0; src = '0; dst = '0; ext = '0;
    repeat (3) @(negedge clk);
    check("R1 strobes in reset", {4'h0, base, dly, en, set}, 8'h00);
    check("R1 bus in reset", bus, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 strobes after edge 1", {4'h0, base, dly, en, set}, 8'h00);
    @(negedge clk);
    check("R1 strobes after edge 2", {4'h0, base, dly, en, set}, 8'h00);
    @(negedge clk);
    check("R2 first phase base rises", {4'h0, base, dly, en, set}, 8'b1010);
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
  endtask

  // R2..R5, R6: strobe pattern over two periods, bus idle
  task automatic t_strobes;
    logic [3:0] pat [4];
    pat[0] = 4'b1010; pat[1] = 4'b1111; pat[2] = 4'b0110; pat[3] = 4'b0000;
    wait_phase(0);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(negedge clk);
      check("R2 base", {7'h0, base}, {7'h0, pat[k%4][3]});
      check("R3 delayed", {7'h0, dly}, {7'h0, pat[k%4][2]});
      check("R4 enable", {7'h0, en}, {7'h0, pat[k%4][1]});
      check("R5 set", {7'h0, set}, {7'h0, pat[k%4][0]});
      check("R6 bus idle", bus, 8'h00);
    end
  endtask

  task automatic do_xfer(logic [2:0] s, logic [1:0] d, logic [7:0] x, logic [7:0] exp, string tag);
    wait_phase(3);
    req = 1'b1; src = s; dst = d; ext = x;
    @(negedge clk);
    check({tag, " bus phase0"}, bus, exp);
    req = 1'b0; src = 3'd0; dst = 2'd0;
    @(negedge clk);
    check({tag, " bus phase1"}, bus, exp);
    @(negedge clk);
    check({tag, " bus phase2"}, bus, exp);
    @(negedge clk);
    check({tag, " R6 bus phase3"}, bus, 8'h00);
    model[d] = exp;
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < NREG; i++)
      do_xfer(3'(i), 2'(i), 8'h00, model[i], tag);
  endtask

  // R10 R6: load bank from the external byte
  task automatic t_load;
    logic [7:0] vals [4];
    vals[0] = 8'hA5; vals[1] = 8'h3C; vals[2] = 8'hF0; vals[3] = 8'h81;
    for (int i = 0; i < NREG; i++)
      do_xfer(3'd4, 2'(i), vals[i], vals[i], "R10 ext load");
    do_xfer(3'd7, 2'd3, 8'h5E, 8'h5E, "R10 ext high index");
    read_all("R7 readback after load");
  endtask

  // R7: copy between registers, others unchanged
  task automatic t_copy;
    do_xfer(3'd0, 2'd2, 8'h00, model[0], "R7 copy r0 to r2");
    read_all("R7 readback after copy");
  endtask

  // R9: self move
  task automatic t_self;
    do_xfer(3'd1, 2'd1, 8'hFF, model[1], "R9 self move");
    read_all("R9 readback after self move");
  endtask

  // R8: late request ignored; accepted move lasts one period
  task automatic t_sampling;
    wait_phase(1);
    req = 1'b1; src = 3'd4; dst = 2'd0; ext = 8'h77;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R8 late request ignored", bus, 8'h00);
    end
    do_xfer(3'd4, 2'd3, 8'h19, 8'h19, "R8 one-shot move");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 move ends after one period", bus, 8'h00);
    end
    read_all("R8 readback");
  endtask

  // R1: reset mid-run clears the bank
  task automatic t_midreset;
    wait_phase(1);
    rst_n = 1'b0;
    #1;
    check("R1 async reset strobes", {4'h0, base, dly, en, set}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    read_all("R1 bank cleared");
  endtask

  initial begin
    t_reset();
    t_strobes();
    t_load();
    t_copy();
    t_self();
    t_sampling();
    t_midreset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule